// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Slave

This block is a receive-only slave on a two-wire serial bus (SCL, SDA). It watches for a start condition, shifts in bytes most significant bit first, acknowledges them by pulling SDA low through an open-drain enable, and loads a bank of eight 8-bit configuration registers. The registers come out of reset with fixed defaults, so a system that never talks to the block still gets a working configuration.

A transfer is one block write of fixed layout. It opens with the slave address byte, then two header bytes that the block must receive but whose values it throws away, then up to eight data bytes that land in registers 0 to 7 in arrival order. Each data byte is committed on the acknowledge clock, so a transfer cut short by a stop keeps every byte already acknowledged. Reads and clock stretching do not exist. Both bus lines are brought into the system clock domain through synchronizers, and all bus events are detected from the synchronized levels.

Top module: `cfg_i2c_wslave`

## Requirements
- R1: After reset, `sda_oe_o` is 0 and the registers hold register 0 = 0x00, registers 1 to 6 = 0xFF, register 7 = 0x0F; `cfg_o[8*k+7:8*k]` carries register k.
- R2: Only the address byte 0xD2 (sent MSB first) is acknowledged; any other first byte is not acknowledged, and no register changes until the next start.
- R3: The second and third bytes of a transfer are acknowledged but their values are stored nowhere and they do not shift the mapping of later bytes.
- R4: Byte n of the transfer (n = 3 to 10, counting the address byte as 0) is stored into register n-3, bit 7 being the first bit received.
- R5: A data byte is stored on the rising SCL edge of its ninth (acknowledge) bit; a stop after that keeps it, and registers whose byte was not completed keep their old value.
- R6: Bytes after the eleventh byte of an addressed transfer are acknowledged and change no register.
- R7: Reserved bits (register 0 bits 7:6, register 7 bits 7:4) always read 0, whatever value is written to them.
- R8: `ss_mode_o` equals bits 1:0 of register 0, the spread-spectrum mode field.
- R9: A repeated start (SDA falling while SCL is high) aborts the current transfer; the next byte is treated as an address byte again.
- R10: `sda_oe_o` is asserted only during the acknowledge bit of an acknowledged byte: it rises after an SCL falling edge and is released at the following SCL falling edge or at a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| cfg_o | output | 64 | Register file contents, register k in bits 8k+7:8k |
| ss_mode_o | output | 2 | Spread-spectrum mode field from register 0 |

## Verification
The assertions take for granted a well-formed bus: SDA moves only while SCL is low except at start and stop, every SCL level lasts longer than the synchronizer latency plus one clock, and the master lets SDA go during the acknowledge bit. The stimulus holds each SCL level for eight system clocks and changes SDA four clocks into the low phase, which keeps all of this true while still placing repeated starts, early stops and over-long frames on the bus. Under these conditions a register may only change one clock after a detected SCL rise while the slave is addressed, and the acknowledge drive may only appear just after an SCL fall.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int BYTE_W      = 8;
    localparam int N_REGS      = 8;
    localparam int HDR_BYTES   = 3;
    localparam int TOTAL_BYTES = HDR_BYTES + N_REGS;
    localparam int IDX_W       = $clog2(TOTAL_BYTES + 1);
    localparam int REG_IDX_W   = $clog2(N_REGS);
    localparam int BITCNT_W    = $clog2(BYTE_W + 1);
    localparam int CFG_W       = N_REGS * BYTE_W;

    localparam logic [BYTE_W-1:0] DEF_SLAVE_ADDR = 8'hD2;
    localparam logic [IDX_W-1:0]  HDR_IDX        = HDR_BYTES[IDX_W-1:0];
    localparam logic [IDX_W-1:0]  END_IDX        = TOTAL_BYTES[IDX_W-1:0];
    localparam logic [BITCNT_W-1:0] FULL_BITS    = BYTE_W[BITCNT_W-1:0];

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic                 valid;
        logic [REG_IDX_W-1:0] idx;
        logic [BYTE_W-1:0]    data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] rsvd_mask(input int unsigned reg_i);
        case (reg_i)
            0:       return 8'hC0;
            7:       return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reset_value(input int unsigned reg_i);
        if (reg_i == 0)
            return 8'h00;
        return 8'hFF & ~rsvd_mask(reg_i);
    endfunction

    function automatic logic [CFG_W-1:0] rsvd_flat();
        logic [CFG_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_REGS; i++)
            m[i*BYTE_W +: BYTE_W] = rsvd_mask(i);
        return m;
    endfunction

endpackage

// File: rtl/cfg_i2c_line_sync.sv
module cfg_i2c_line_sync
    import cfg_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/cfg_i2c_byte_engine.sv
module cfg_i2c_byte_engine
    import cfg_i2c_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SLAVE_ADDR = DEF_SLAVE_ADDR
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    output logic     sda_oe_o,
    output logic     addr_ok_o,
    output wr_req_t  wr_o
);

    rx_state_e           state;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [IDX_W-1:0]    byte_idx;
    logic                addr_ok;
    logic                addr_match;
    logic                give_ack;
    logic [IDX_W-1:0]    rel_idx;

    assign addr_match = (shreg == SLAVE_ADDR);
    assign give_ack   = (byte_idx == '0) ? addr_match : addr_ok;
    assign rel_idx    = byte_idx - HDR_IDX;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_idx <= '0;
            addr_ok  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (ev.start) begin
            state    <= ST_SHIFT;
            bit_cnt  <= '0;
            byte_idx <= '0;
            addr_ok  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (ev.stop) begin
            state    <= ST_IDLE;
            addr_ok  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else begin
            unique case (state)
                ST_SHIFT: begin
                    if (ev.scl_rise && bit_cnt != FULL_BITS) begin
                        shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (ev.scl_fall && bit_cnt == FULL_BITS) begin
                        if (give_ack) begin
                            state    <= ST_ACK;
                            sda_oe_o <= 1'b1;
                        end else begin
                            state    <= ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_rise && byte_idx == '0)
                        addr_ok <= 1'b1;
                    if (ev.scl_fall) begin
                        sda_oe_o <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= ST_SHIFT;
                        if (byte_idx != END_IDX)
                            byte_idx <= byte_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign addr_ok_o = addr_ok;

    always_comb begin
        wr_o.valid = (state == ST_ACK) && ev.scl_rise && addr_ok && !ev.start && !ev.stop
                     && (byte_idx >= HDR_IDX) && (byte_idx < END_IDX);
        wr_o.idx   = rel_idx[REG_IDX_W-1:0];
        wr_o.data  = shreg;
    end

endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile
    import cfg_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wr,
    output logic [CFG_W-1:0] cfg_o
);

    generate
        for (genvar g = 0; g < N_REGS; g++) begin : g_reg
            localparam logic [BYTE_W-1:0] KEEP = ~rsvd_mask(g);
            logic [BYTE_W-1:0] val;
            always_ff @(posedge clk) begin
                if (rst)
                    val <= reset_value(g);
                else if (wr.valid && wr.idx == REG_IDX_W'(g))
                    val <= wr.data & KEEP;
            end
            assign cfg_o[g*BYTE_W +: BYTE_W] = val;
        end
    endgenerate

endmodule

// File: rtl/cfg_i2c_wslave.sv
module cfg_i2c_wslave
    import cfg_i2c_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] SLAVE_ADDR  = DEF_SLAVE_ADDR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic [1:0]       ss_mode_o
);

    line_ev_t line_ev;
    wr_req_t  wr_req;
    logic     addr_ok;

    cfg_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (line_ev)
    );

    cfg_i2c_byte_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (line_ev),
        .sda_oe_o  (sda_oe_o),
        .addr_ok_o (addr_ok),
        .wr_o      (wr_req)
    );

    cfg_i2c_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_req),
        .cfg_o (cfg_o)
    );

    assign ss_mode_o = cfg_o[1:0];

endmodule

// File: rtl/cfg_i2c_wslave_chk.sv
module cfg_i2c_wslave_chk
    import cfg_i2c_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input line_ev_t         ev,
    input logic             addr_ok,
    input logic             sda_oe,
    input logic [CFG_W-1:0] cfg
);

    localparam logic [CFG_W-1:0] RSVD = rsvd_flat();

    // R5: registers move only one clock after a detected SCL rise
    p_commit_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> $past(ev.scl_rise));

    // R2: registers move only while the slave is addressed
    p_write_needs_addr_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> $past(addr_ok));

    // R10: a stop releases the acknowledge drive
    p_release_on_stop_r10: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    // R10: the acknowledge drive starts just after SCL falls
    p_ack_after_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(ev.scl_fall));

    // R7: reserved bits stay clear
    p_rsvd_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg & RSVD) == '0);

    // R9: a start drops the addressed condition
    p_start_unaddress_r9: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !addr_ok);

endmodule

bind cfg_i2c_wslave cfg_i2c_wslave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ev      (line_ev),
    .addr_ok (addr_ok),
    .sda_oe  (sda_oe_o),
    .cfg     (cfg_o)
);

// File: tb/cfg_i2c_wslave_tb.sv
module cfg_i2c_wslave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe_o;
    logic [63:0] cfg_o;
    logic [1:0]  ss_mode_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    bit done     = 1'b0;

    logic [7:0]  exp_reg [8];
    logic [63:0] exp_flat;

    assign sda_line = sda_m & ~sda_oe_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_i2c_wslave u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe_o),
        .cfg_o     (cfg_o),
        .ss_mode_o (ss_mode_o)
    );

    always_comb begin
        for (int i = 0; i < 8; i++)
            exp_flat[i*8 +: 8] = exp_reg[i];
    end

    function automatic logic [7:0] b_rsvd(input int k);
        if (k == 0) return 8'hC0;
        if (k == 7) return 8'hF0;
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // R5 R4: model compared on every clock outside the commit window
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            n_checks++;
            if (cfg_o !== exp_flat) begin
                n_fail++;
                $display("FAIL R5 per-clock cfg act=%h exp=%h", cfg_o, exp_flat);
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        if (scl == 1'b0) begin
            sda_m = 1'b1;
            wq(HALF);
            scl = 1'b1;
            wq(2*HALF);
        end
        sda_m = 1'b0;
        wq(2*HALF);
        scl = 1'b0;
    endtask

    task automatic do_stop();
        wq(HALF);
        sda_m = 1'b0;
        wq(HALF);
        scl = 1'b1;
        wq(2*HALF);
        sda_m = 1'b1;
        wq(2*HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                             input int st_idx, input string tag);
        for (int i = 7; i >= 0; i--) begin
            wq(HALF);
            sda_m = b[i];
            wq(HALF);
            scl = 1'b1;
            wq(HALF);
            if (i == 4)
                chk(sda_oe_o === 1'b0, "R10", "no drive in data bit", 64'(sda_oe_o), 64'd0);
            wq(HALF);
            scl = 1'b0;
        end
        wq(HALF);
        sda_m = 1'b1;
        wq(HALF);
        chk(sda_oe_o === exp_ack, tag, "ack drive", 64'(sda_oe_o), 64'(exp_ack));
        cmp_en = 1'b0;
        scl = 1'b1;
        wq(2*HALF);
        if (st_idx >= 0)
            exp_reg[st_idx] = b & ~b_rsvd(st_idx);
        cmp_en = 1'b1;
        scl = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] q[$], input string tag);
        bit hit = 1'b0;
        for (int n = 0; n < q.size(); n++) begin
            bit ack;
            int st;
            ack = (n == 0) ? (q[n] == 8'hD2) : hit;
            st  = (hit && n >= 3 && n < 11) ? n - 3 : -1;
            send_byte(q[n], ack, st, tag);
            if (n == 0) hit = (q[n] == 8'hD2);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=0", WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp_reg[0] = 8'h00;
        for (int i = 1; i < 7; i++) exp_reg[i] = 8'hFF;
        exp_reg[7] = 8'h0F;
        wq(5);
        rst = 1'b0;
        wq(3);

        // R1: reset values and idle bus
        chk(cfg_o === 64'h0FFF_FFFF_FFFF_FF00, "R1", "reset cfg", cfg_o, 64'h0FFF_FFFF_FFFF_FF00);
        chk(sda_oe_o === 1'b0, "R1", "reset sda_oe", 64'(sda_oe_o), 64'd0);
        chk(ss_mode_o === 2'b00, "R8", "reset ss_mode", 64'(ss_mode_o), 64'd0);
        cmp_en = 1'b1;

        // R4 R3: full transfer, header values must not land anywhere
        do_start();
        send_frame('{8'hD2, 8'h5A, 8'hA7, 8'h3E, 8'h11, 8'h22, 8'h80,
                     8'h01, 8'h7F, 8'hC3, 8'h9B}, "R3");
        do_stop();
        chk(cfg_o === 64'h0BC3_7F01_8022_113E, "R4", "full frame cfg",
            cfg_o, 64'h0BC3_7F01_8022_113E);
        chk(cfg_o[7:0] === 8'h3E, "R3", "reg0 not header", 64'(cfg_o[7:0]), 64'h3E);
        chk(ss_mode_o === 2'b10, "R8", "ss_mode after write", 64'(ss_mode_o), 64'd2);

        // R2: wrong addresses, last bit and first bit off
        do_start();
        send_frame('{8'hD3, 8'h00, 8'h08, 8'h55, 8'h55, 8'h55, 8'h55,
                     8'h55, 8'h55, 8'h55, 8'h55}, "R2");
        do_stop();
        do_start();
        send_frame('{8'h52, 8'h00, 8'h08, 8'hAA, 8'hAA, 8'hAA}, "R2");
        do_stop();
        chk(cfg_o === 64'h0BC3_7F01_8022_113E, "R2", "unaddressed unchanged",
            cfg_o, 64'h0BC3_7F01_8022_113E);

        // R5: early stop keeps completed bytes only
        do_start();
        send_frame('{8'hD2, 8'hFF, 8'hFF, 8'h01, 8'h44, 8'h66}, "R5");
        do_stop();
        chk(cfg_o === 64'h0BC3_7F01_8066_4401, "R5", "partial frame cfg",
            cfg_o, 64'h0BC3_7F01_8066_4401);
        chk(ss_mode_o === 2'b01, "R8", "ss_mode after partial", 64'(ss_mode_o), 64'd1);

        // R6 R7: over-long frame, reserved bits written as ones
        do_start();
        send_frame('{8'hD2, 8'h00, 8'h00, 8'hFF, 8'h10, 8'h20, 8'h30,
                     8'h40, 8'h50, 8'h60, 8'hFF, 8'hEE, 8'hDD}, "R6");
        do_stop();
        chk(cfg_o === 64'h0F60_5040_3020_103F, "R6", "extra bytes not stored",
            cfg_o, 64'h0F60_5040_3020_103F);
        chk(cfg_o[7:6] === 2'b00, "R7", "reg0 reserved", 64'(cfg_o[7:6]), 64'd0);
        chk(cfg_o[63:60] === 4'h0, "R7", "reg7 reserved", 64'(cfg_o[63:60]), 64'd0);
        chk(ss_mode_o === 2'b11, "R8", "ss_mode all ones", 64'(ss_mode_o), 64'd3);

        // R9: repeated start realigns the byte positions
        do_start();
        send_frame('{8'hD2, 8'h00, 8'h00, 8'h02, 8'h99}, "R9");
        do_start();
        send_frame('{8'hD2, 8'h12, 8'h34, 8'h81, 8'h5C}, "R9");
        do_stop();
        chk(cfg_o === 64'h0F60_5040_3020_5C01, "R9", "restart realign",
            cfg_o, 64'h0F60_5040_3020_5C01);

        // R2 R9: restart into a foreign address writes nothing
        do_start();
        send_frame('{8'hD2, 8'h00, 8'h00}, "R9");
        do_start();
        send_frame('{8'hA4, 8'h00, 8'h00, 8'h77}, "R2");
        do_stop();
        chk(cfg_o === 64'h0F60_5040_3020_5C01, "R2", "foreign after restart",
            cfg_o, 64'h0F60_5040_3020_5C01);
        chk(sda_oe_o === 1'b0, "R10", "idle after stop", 64'(sda_oe_o), 64'd0);

        wq(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule